// File: doc/BRIEF.md
# Dual-Channel Audio Peak Level Meter

This block watches two audio sample streams and keeps, for each stream, the loudest level seen since the host last looked at it. Each level is held as a 6-bit attenuation code in 1 dB steps below full scale. Code 0 means full scale. Code 63 means 63 dB down or quieter. Because a smaller code means a louder signal, each channel's register keeps the smallest code it has seen.

Samples arrive as signed two's complement words on a 24-bit bus, together with a strobe that is shared by both channels. A width select sets whether each word holds 16, 20 or 24 significant bits. The words are aligned to the top of the bus, so full scale is the same in every width. Each channel has its own read strobe. During the cycle in which the strobe is high, the channel's output shows the held peak. At the clock edge that ends that cycle, the register restarts from the quietest code. A sample that arrives on that same edge is not lost.

Top module: `peak_meter`

## Requirements
- R1: After reset both peak outputs read 63.
- R2: For a sample of magnitude M, the code is the number of k in 1..63 for which M < round(2^23 * 10^(-k/20)). A magnitude at or above the 1 dB threshold gives 0, and a zero sample gives 63.
- R3: A peak output only ever moves to a smaller code while no read is issued on its channel. A quieter sample leaves the held code unchanged.
- R4: While a channel's read strobe is high, its output shows the held peak. At the next clock edge that register becomes 63 if no sample is valid on that edge.
- R5: If a sample is valid on the same edge as a read, the register takes that sample's code instead of 63.
- R6: A read on one channel never alters the other channel's peak.
- R7: The most negative input word (0x800000 after width masking) is treated as the largest positive magnitude and yields code 0.
- R8: width_sel 2'b00 selects 16-bit samples and ignores bits [7:0]. 2'b01 selects 20-bit samples and ignores bits [3:0]. 2'b10 and 2'b11 select 24-bit samples and use every bit.
- R9: A negative sample yields the same code as a positive sample of equal magnitude.
- R10: When neither the sample strobe nor the read strobe is high, the channel's peak does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| width_sel | input | 2 | Sample width: 00 = 16, 01 = 20, 1x = 24 bits |
| smp_valid | input | 1 | Both sample words are valid this cycle |
| smp_a | input | 24 | Channel A sample, top-aligned two's complement |
| smp_b | input | 24 | Channel B sample, top-aligned two's complement |
| rd_a | input | 1 | Read strobe for channel A; clears after this cycle |
| rd_b | input | 1 | Read strobe for channel B; clears after this cycle |
| peak_a | output | 6 | Channel A held peak code |
| peak_b | output | 6 | Channel B held peak code |

## Verification
The hardest case to create is a word whose discarded low bits decide which side of a 1 dB threshold it falls on. The stimulus chooses a value a few tens of LSBs above the -20 dB threshold, with low bits that drop it below that threshold once the bottom 8 bits are masked. It then reads the same value back in all three width settings. A second hard case is a read and a sample that land on the same edge. A long random phase makes this happen often on both channels, with each read's expected value predicted by a scoreboard model whose thresholds are computed in floating point. The full sweep places one sample in the middle of each 1 dB step, so that threshold rounding cannot blur any code.

// File: rtl/pkmeter_pkg.sv
package pkmeter_pkg;

  // 10^(-1/20) in unsigned fixed point with 32 fractional bits
  localparam logic [95:0] DB_STEP_RATIO = 96'd3827893632;

  typedef enum logic [1:0] {
    WSEL_16 = 2'b00,
    WSEL_20 = 2'b01,
    WSEL_24 = 2'b10
  } width_sel_e;

  // Magnitude threshold k dB below a full scale of 2^mag_w, rounded
  function automatic logic [63:0] level_threshold(input int mag_w, input int k);
    logic [95:0] acc;
    acc = 96'd1 << (mag_w + 16);
    for (int i = 0; i < k; i++) begin
      acc = (acc * DB_STEP_RATIO) >> 32;
    end
    acc = (acc + 96'd32768) >> 16;
    return acc[63:0];
  endfunction

endpackage

// File: rtl/pkm_mag.sv
module pkm_mag #(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 20
) (
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-2:0] mag
);
  localparam int DROP_NARROW = DATA_W - NARROW_W;
  localparam int DROP_MID    = DATA_W - MID_W;
  localparam logic [DATA_W-1:0] KEEP_NARROW = {{NARROW_W{1'b1}}, {DROP_NARROW{1'b0}}};
  localparam logic [DATA_W-1:0] KEEP_MID    = {{MID_W{1'b1}}, {DROP_MID{1'b0}}};
  localparam logic [DATA_W-1:0] MOST_NEG    = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] negated;

  always_comb begin
    case (width_sel)
      pkmeter_pkg::WSEL_16: keep = KEEP_NARROW;
      pkmeter_pkg::WSEL_20: keep = KEEP_MID;
      default:              keep = '1;
    endcase
    masked  = sample & keep;
    negated = -masked;
    if (masked == MOST_NEG) begin
      mag = '1;
    end else if (masked[DATA_W-1]) begin
      mag = negated[DATA_W-2:0];
    end else begin
      mag = masked[DATA_W-2:0];
    end
  end
endmodule

// File: rtl/pkm_db_enc.sv
module pkm_db_enc #(
  parameter int MAG_W  = 23,
  parameter int CODE_W = 6
) (
  input  logic [MAG_W-1:0]  mag,
  output logic [CODE_W-1:0] code
);
  localparam int STEPS = (1 << CODE_W) - 1;
  localparam int THR_W = MAG_W + 1;

  logic [STEPS-1:0] quieter;

  for (genvar k = 1; k <= STEPS; k++) begin : g_step
    localparam logic [THR_W-1:0] LIMIT = THR_W'(pkmeter_pkg::level_threshold(MAG_W, k));
    assign quieter[k-1] = ({1'b0, mag} < LIMIT);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < STEPS; i++) begin
      code = code + CODE_W'(quieter[i]);
    end
  end
endmodule

// File: rtl/pkm_hold.sv
module pkm_hold #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              rd_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] peak_o
);
  localparam logic [CODE_W-1:0] QUIET = '1;

  logic [CODE_W-1:0] peak_q;
  logic [CODE_W-1:0] peak_d;
  logic [CODE_W-1:0] base;
  logic              en;

  always_comb begin
    en   = valid_i | rd_i;
    base = rd_i ? QUIET : peak_q;
    if (valid_i && (code_i < base)) begin
      peak_d = code_i;
    end else begin
      peak_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= QUIET;
    end else if (en) begin
      peak_q <= peak_d;
    end
  end

  assign peak_o = peak_q;

  assert_hold_louder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (peak_o <= $past(peak_o)));

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !valid_i) |=> (peak_o == QUIET));

  assert_read_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && valid_i) |=> (peak_o == $past(code_i)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !valid_i) |=> $stable(peak_o));
endmodule

// File: rtl/peak_meter.sv
module peak_meter #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_sel,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic              rd_a,
  input  logic              rd_b,
  output logic [CODE_W-1:0] peak_a,
  output logic [CODE_W-1:0] peak_b
);
  localparam int CHANNELS = 2;
  localparam int MAG_W    = DATA_W - 1;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  logic [DATA_W-1:0] ch_smp  [CHANNELS];
  logic              ch_rd   [CHANNELS];
  logic [CODE_W-1:0] ch_peak [CHANNELS];

  assign ch_smp[0] = smp_a;
  assign ch_smp[1] = smp_b;
  assign ch_rd[0]  = rd_a;
  assign ch_rd[1]  = rd_b;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    logic [MAG_W-1:0]  mag;
    logic [CODE_W-1:0] code;

    pkm_mag #(.DATA_W(DATA_W)) u_mag (
      .width_sel (width_sel),
      .sample    (ch_smp[g]),
      .mag       (mag)
    );

    pkm_db_enc #(.MAG_W(MAG_W), .CODE_W(CODE_W)) u_enc (
      .mag  (mag),
      .code (code)
    );

    pkm_hold #(.CODE_W(CODE_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .valid_i (smp_valid),
      .rd_i    (ch_rd[g]),
      .code_i  (code),
      .peak_o  (ch_peak[g])
    );
  end

  assign peak_a = ch_peak[0];
  assign peak_b = ch_peak[1];

  assert_most_neg_full_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (smp_valid && !rd_a && (smp_a == {1'b1, {(DATA_W-1){1'b0}}})) |=> (peak_a == '0));

  assert_zero_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (smp_valid && !rd_a && (smp_a == '0)) |=> (peak_a == $past(peak_a)));

  assert_chan_isolated_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_a && !rd_b && !smp_valid) |=> $stable(peak_b));
endmodule

// File: tb/sim_peak_meter.sv
`timescale 1ns/1ps
module sim_peak_meter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  width_sel;
  logic        smp_valid;
  logic [23:0] smp_a, smp_b;
  logic        rd_a, rd_b;
  logic [5:0]  peak_a, peak_b;

  always #2.5 clk = ~clk;

  peak_meter u0 (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .smp_valid(smp_valid),
    .smp_a(smp_a), .smp_b(smp_b), .rd_a(rd_a), .rd_b(rd_b),
    .peak_a(peak_a), .peak_b(peak_b)
  );

  int thr [64];
  int mids [64];
  logic [5:0] qa [$];
  logic [5:0] qb [$];
  string ta [$];
  string tb [$];
  int checks = 0;
  int errors = 0;
  int pa = 63;
  int pb = 63;
  bit started = 0;
  bit done = 0;

  function automatic int code_of(logic [23:0] s, logic [1:0] ws);
    logic [23:0] m;
    int v, mag, c;
    case (ws)
      2'b00:   m = s & 24'hFFFF00;
      2'b01:   m = s & 24'hFFFFF0;
      default: m = s;
    endcase
    v = int'($signed(m));
    if (v == -8388608) mag = 8388607;
    else if (v < 0) mag = -v;
    else mag = v;
    c = 0;
    for (int k = 1; k < 64; k++) if (mag < thr[k]) c++;
    return c;
  endfunction

  function automatic logic [23:0] neg(int x);
    return 24'(-x);
  endfunction

  task automatic op(input logic v, input logic [23:0] a, input logic [23:0] b,
                    input logic ra, input logic rb, input string tag);
    int ca, cb;
    @(posedge clk); #1;
    smp_valid = v; smp_a = a; smp_b = b; rd_a = ra; rd_b = rb;
    if (ra) begin qa.push_back(6'(pa)); ta.push_back(tag); end
    if (rb) begin qb.push_back(6'(pb)); tb.push_back(tag); end
    ca = code_of(a, width_sel);
    cb = code_of(b, width_sel);
    if (ra) pa = v ? ca : 63; else if (v && ca < pa) pa = ca;
    if (rb) pb = v ? cb : 63; else if (v && cb < pb) pb = cb;
  endtask

  task automatic setw(input logic [1:0] w);
    @(posedge clk); #1;
    smp_valid = 0; rd_a = 0; rd_b = 0; width_sel = w;
  endtask

  always @(negedge clk) begin
    if (started) begin
      if (rd_a) begin
        if (qa.size() == 0) begin
          errors++; checks++;
          $display("FAIL scoreboard a: got %0d expected none", peak_a);
        end else begin
          logic [5:0] e; string t;
          e = qa.pop_front(); t = ta.pop_front(); checks++;
          if (peak_a !== e) begin
            errors++;
            $display("FAIL %s channel a: got %0d expected %0d", t, peak_a, e);
          end
        end
      end
      if (rd_b) begin
        if (qb.size() == 0) begin
          errors++; checks++;
          $display("FAIL scoreboard b: got %0d expected none", peak_b);
        end else begin
          logic [5:0] e; string t;
          e = qb.pop_front(); t = tb.pop_front(); checks++;
          if (peak_b !== e) begin
            errors++;
            $display("FAIL %s channel b: got %0d expected %0d", t, peak_b, e);
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k < 64; k++) thr[k] = $rtoi(8388608.0 * $pow(10.0, -k / 20.0) + 0.5);
    thr[0] = 8388608;
    for (int n = 0; n < 63; n++) mids[n] = $rtoi(8388608.0 * $pow(10.0, -(n + 0.5) / 20.0));
    mids[63] = 0;

    rst_n = 0; width_sel = 2'b10; smp_valid = 0; smp_a = 0; smp_b = 0; rd_a = 0; rd_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (peak_a !== 6'd63 || peak_b !== 6'd63) begin
      errors++;
      $display("FAIL R1 reset: got %0d/%0d expected 63/63", peak_a, peak_b);
    end
    @(posedge clk); #1; rst_n = 1;
    repeat (4) @(posedge clk);
    started = 1;

    op(0, 0, 0, 1, 1, "R1");
    op(1, 24'(mids[10]), 24'(mids[40]), 0, 0, "R3");
    op(1, 24'(mids[20]), 24'(mids[50]), 0, 0, "R3");
    op(0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 0, "R3");
    op(0, 0, 0, 1, 0, "R4");
    op(0, 0, 0, 0, 1, "R6");
    op(1, 24'(mids[5]), 0, 1, 0, "R5");
    op(0, 0, 0, 1, 0, "R5");
    op(1, 24'h800000, 24'h7FFFFF, 0, 0, "R7");
    op(0, 0, 0, 1, 1, "R7");
    op(1, 0, neg(mids[30]), 0, 0, "R2");
    op(0, 0, 0, 1, 1, "R9");
    op(1, 24'(mids[30]), neg(mids[30]), 0, 0, "R9");
    op(0, 0, 0, 1, 1, "R9");

    for (int n = 0; n < 64; n++) begin
      op(1, 24'(mids[n]), neg(mids[63 - n]), 0, 0, "R2");
      op(0, 0, 0, 1, 1, "R2");
    end

    foreach (qa[i]) ; // placeholder-free no-op keeps queues untouched
    setw(2'b00);
    op(1, 24'd838900, neg(838900), 0, 0, "R8");
    op(0, 0, 0, 1, 1, "R8");
    setw(2'b01);
    op(1, 24'd838900, neg(838900), 0, 0, "R8");
    op(0, 0, 0, 1, 1, "R8");
    setw(2'b10);
    op(1, 24'd838900, neg(838900), 0, 0, "R8");
    op(0, 0, 0, 1, 1, "R8");
    setw(2'b11);
    op(1, 24'd838900, 24'h0000FF, 0, 0, "R8");
    op(0, 0, 0, 1, 1, "R8");

    for (int pass = 0; pass < 2; pass++) begin
      setw(pass == 0 ? 2'b10 : 2'b00);
      for (int i = 0; i < 1500; i++) begin
        logic [23:0] a, b;
        int na, nb;
        na = $urandom_range(63); nb = $urandom_range(63);
        a = ($urandom_range(1) == 1) ? neg(mids[na]) : 24'(mids[na]);
        b = ($urandom_range(1) == 1) ? neg(mids[nb]) : 24'(mids[nb]);
        if ($urandom_range(39) == 0) a = 24'h800000;
        op(1'($urandom_range(1)), a, b, ($urandom_range(3) == 0), ($urandom_range(3) == 0), "R3 R5 R6");
      end
      op(0, 0, 0, 1, 1, "R4");
    end

    op(0, 0, 0, 0, 0, "R10");
    repeat (4) @(posedge clk);
    if (qa.size() != 0 || qb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: %0d/%0d reads left, expected 0/0", qa.size(), qb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule